// File: doc/BRIEF.md
# Frame-Separation Receive Strobe Generator

This block sits at the frame-timing front of a four-channel time-slotted voice interface. A single separation input pulses once per 8 kHz frame, and every frame the block measures how many bit-clock samples that pulse stays high. Its first sample high marks the start of time slot 0. The width is turned into a receive offset. Each channel then gets an internal receive strobe placed that many bit clocks after the rising edge of its own transmit frame sync.

A width of one clock makes the transmit and receive syncs coincident, and the strobe comes in the cycle right after the sync is seen. A wider pulse adds one cycle of offset for each extra clock of width. A width is latched when the pulse ends and takes effect at the start of the next frame, so the current frame keeps a steady offset. An offset of one frame length minus one is not allowed. When that value is measured, the block raises a configuration-error flag and falls back to coincident timing. All pins are plain level or pulse controls: the block carries no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `rxsep_strobe_gen`

## Requirements
- R1: After reset, every receive strobe, the slot-0 marker and the error flag are low, and the offset in force is zero (coincident).
- R2: When the separation input is sampled high after being sampled low, the slot-0 marker is high for exactly the following cycle and low in the cycle after that.
- R3: With an offset d greater than zero in force, a channel's strobe is high in the cycle d+1 cycles after the cycle in which its transmit sync was first sampled high, and it is not high earlier.
- R4: When the latched separation width is one sample, a channel's strobe is high in the cycle right after the cycle in which its sync was first sampled high.
- R5: A width measured at the end of a pulse is used only from the next sampled rise of the separation input onward. Syncs in the same frame, including those after the pulse ends, keep the offset that was in force when the frame began.
- R6: A measured width of FRAME_CLKS samples or more, which is an offset of FRAME_CLKS-1 or more, sets the error flag from the cycle after the pulse ends. The next frame then uses offset zero.
- R7: The error flag changes only in the cycle after a separation pulse ends. It clears when an allowed width is measured.
- R8: Channels are timed independently. A sync held high for several cycles gives exactly one single-cycle strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sep_in | input | 1 | Frame-separation pulse, once per frame |
| fsx_in | input | NCH | Per-channel transmit frame syncs |
| rx_stb | output | NCH | Per-channel receive strobes, one cycle wide |
| slot0_mark | output | 1 | One-cycle marker for the start of time slot 0 |
| cfg_err | output | 1 | Measured separation width gives a forbidden offset |

## Verification
The hardest case to reach is the forbidden width. The separation pulse has to stay high for a whole frame length, and the fallback only shows up one frame later on strobes that would otherwise land far out. The stimulus first programs a large offset of 200 cycles, so that the frame holding the overlong pulse checks strobes at that offset. It then runs a short frame whose strobes must come back coincident while the error flag is still set. A further frame checks that the flag clears. Between frames the driver waits until every expected strobe has been matched, so strobes that land late never overlap the next frame.

// File: rtl/rxsep_pkg.sv
package rxsep_pkg;
  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_ARMED = 2'd1,
    CH_FIRE  = 2'd2
  } ch_state_e;

  // Offset rule: width of one (or less) means coincident, else width-1
  function automatic int unsigned width_to_offset(input int unsigned w);
    return (w <= 1) ? 0 : w - 1;
  endfunction
endpackage

// File: rtl/rxsep_edge.sv
module rxsep_edge #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig_in,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sig_in;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign rise[i] = sig_in[i] & ~prev_q[i];
  end
endmodule

// File: rtl/rxsep_width_meter.sv
module rxsep_width_meter
  import rxsep_pkg::*;
#(
  parameter int FRAME_CLKS = 256,
  parameter int CW = $clog2(FRAME_CLKS) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sep_in,
  input  logic          sep_rise,
  output logic [CW-1:0] eff_dly,
  output logic          cfg_err
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};
  localparam int unsigned   LIMIT   = FRAME_CLKS;

  logic [CW-1:0] width_q;
  logic [CW-1:0] pend_q;
  logic [CW-1:0] act_q;
  logic          err_q;
  logic          pulse_end;

  assign pulse_end = !sep_in && (width_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      width_q <= '0;
      pend_q  <= '0;
      act_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      if (sep_in) begin
        if (sep_rise)               width_q <= CW'(1);
        else if (width_q != CNT_MAX) width_q <= width_q + CW'(1);
      end else if (pulse_end) begin
        width_q <= '0;
        if (int'(width_q) >= LIMIT) begin
          pend_q <= '0;
          err_q  <= 1'b1;
        end else begin
          pend_q <= CW'(width_to_offset(int'(width_q)));
          err_q  <= 1'b0;
        end
      end
      if (sep_rise) act_q <= pend_q;
    end
  end

  // A sync seen on the same edge as the frame start already uses the new value
  assign eff_dly = sep_rise ? pend_q : act_q;
  assign cfg_err = err_q;
endmodule

// File: rtl/rxsep_rx_chan.sv
module rxsep_rx_chan
  import rxsep_pkg::*;
#(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_rise,
  input  logic [CW-1:0] dly,
  output logic          stb
);
  ch_state_e     st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= CH_IDLE;
      cnt_q <= '0;
    end else if (sync_rise) begin
      if (dly == '0) begin
        st_q <= CH_FIRE;
      end else begin
        st_q  <= CH_ARMED;
        cnt_q <= dly;
      end
    end else begin
      case (st_q)
        CH_ARMED: begin
          if (cnt_q == CW'(1)) st_q <= CH_FIRE;
          else                 cnt_q <= cnt_q - CW'(1);
        end
        CH_FIRE: st_q <= CH_IDLE;
        default: st_q <= CH_IDLE;
      endcase
    end
  end

  assign stb = (st_q == CH_FIRE);
endmodule

// File: rtl/rxsep_strobe_gen.sv
module rxsep_strobe_gen #(
  parameter int FRAME_CLKS = 256,
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sep_in,
  input  logic [NCH-1:0] fsx_in,
  output logic [NCH-1:0] rx_stb,
  output logic           slot0_mark,
  output logic           cfg_err
);
  localparam int CW = $clog2(FRAME_CLKS) + 1;

  logic           sep_rise;
  logic [NCH-1:0] fsx_rise;
  logic [CW-1:0]  eff_dly;
  logic           slot0_q;

  rxsep_edge #(.W(1)) u_sep_edge (
    .clk(clk), .rst_n(rst_n), .sig_in(sep_in), .rise(sep_rise)
  );

  rxsep_edge #(.W(NCH)) u_fsx_edge (
    .clk(clk), .rst_n(rst_n), .sig_in(fsx_in), .rise(fsx_rise)
  );

  rxsep_width_meter #(.FRAME_CLKS(FRAME_CLKS), .CW(CW)) u_meter (
    .clk(clk), .rst_n(rst_n), .sep_in(sep_in), .sep_rise(sep_rise),
    .eff_dly(eff_dly), .cfg_err(cfg_err)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    rxsep_rx_chan #(.CW(CW)) u_chan (
      .clk(clk), .rst_n(rst_n), .sync_rise(fsx_rise[c]),
      .dly(eff_dly), .stb(rx_stb[c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) slot0_q <= 1'b0;
    else        slot0_q <= sep_rise;
  end

  assign slot0_mark = slot0_q;
endmodule

// File: rtl/rxsep_strobe_gen_chk.sv
module rxsep_strobe_gen_chk #(
  parameter int NCH = 4,
  parameter int CW = 9
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sep_in,
  input logic [NCH-1:0] fsx_in,
  input logic [NCH-1:0] rx_stb,
  input logic           slot0_mark,
  input logic           cfg_err,
  input logic [CW-1:0]  eff_dly
);
  logic           sep_q;
  logic [NCH-1:0] fsx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sep_q <= 1'b0;
      fsx_q <= '0;
    end else begin
      sep_q <= sep_in;
      fsx_q <= fsx_in;
    end
  end

  a_r2_slot0_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (sep_in && !sep_q) |=> slot0_mark);

  a_r2_slot0_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    slot0_mark |=> !slot0_mark);

  a_r7_err_moves_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    !(sep_q && !sep_in) |=> $stable(cfg_err));

  a_r6_err_gives_coinc: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && sep_in && !sep_q) |-> (eff_dly == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    a_r4_coincident: assert property (@(posedge clk) disable iff (!rst_n)
      (fsx_in[c] && !fsx_q[c] && eff_dly == '0) |=> rx_stb[c]);

    a_r3_not_early: assert property (@(posedge clk) disable iff (!rst_n)
      (fsx_in[c] && !fsx_q[c] && eff_dly != '0) |=> !rx_stb[c]);

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rx_stb[c] |=> !rx_stb[c]);
  end
endmodule

bind rxsep_strobe_gen rxsep_strobe_gen_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sep_in(sep_in), .fsx_in(fsx_in),
  .rx_stb(rx_stb), .slot0_mark(slot0_mark), .cfg_err(cfg_err),
  .eff_dly(eff_dly)
);

// File: tb/tb_rxsep_strobe_gen.sv
module tb_rxsep_strobe_gen;
  localparam int FRAME_CLKS = 256;
  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           sep_in = 1'b0;
  logic [NCH-1:0] fsx_in = '0;
  logic [NCH-1:0] rx_stb;
  logic           slot0_mark;
  logic           cfg_err;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 1'b0;

  typedef struct { int at; int ch; } exp_t;
  exp_t expq[$];

  rxsep_strobe_gen #(.FRAME_CLKS(FRAME_CLKS), .NCH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .sep_in(sep_in), .fsx_in(fsx_in),
    .rx_stb(rx_stb), .slot0_mark(slot0_mark), .cfg_err(cfg_err)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Monitor: compare every strobe against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      while (expq.size() > 0 && expq[0].at < cyc) begin
        check(1'b0, "R3/R8 missing strobe", -1, expq[0].at);
        void'(expq.pop_front());
      end
      for (int c = 0; c < NCH; c++) begin
        if (rx_stb[c]) begin
          if (expq.size() == 0) begin
            check(1'b0, "R8 unexpected strobe", cyc, c);
          end else begin
            check(expq[0].at == cyc && expq[0].ch == c, "R3/R4 strobe timing",
                  cyc * 10 + c, expq[0].at * 10 + expq[0].ch);
            void'(expq.pop_front());
          end
        end
      end
    end
  end

  // Driver: one frame. slot < 0 disables a channel; d is the offset expected in force
  task automatic run_frame(input int w, input int s0, input int s1, input int s2,
                           input int s3, input int hold, input int d);
    int slots[NCH];
    int len;
    slots[0] = s0; slots[1] = s1; slots[2] = s2; slots[3] = s3;
    len = w;
    for (int c = 0; c < NCH; c++)
      if (slots[c] >= 0 && slots[c] * 8 + hold > len) len = slots[c] * 8 + hold;
    len += 2;
    for (int t = 0; t < len; t++) begin
      @(negedge clk);
      if (t == 1) check(slot0_mark == 1'b1, "R2 slot0 high", slot0_mark, 1);
      if (t == 2) check(slot0_mark == 1'b0, "R2 slot0 low", slot0_mark, 0);
      sep_in = (t < w);
      for (int c = 0; c < NCH; c++) begin
        bit nv;
        nv = (slots[c] >= 0) && (t >= slots[c] * 8) && (t < slots[c] * 8 + hold);
        if (nv && !fsx_in[c]) begin
          exp_t e;
          e.at = cyc + 1 + d;
          e.ch = c;
          expq.push_back(e);
        end
        fsx_in[c] = nv;
      end
    end
    @(negedge clk);
    sep_in = 1'b0;
    fsx_in = '0;
    for (int k = 0; k < 1000 && expq.size() > 0; k++) @(negedge clk);
    check(expq.size() == 0, "R3 scoreboard drained", expq.size(), 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(rx_stb == '0, "R1 strobes after reset", rx_stb, 0);
    check(slot0_mark == 1'b0, "R1 slot0 after reset", slot0_mark, 0);
    check(cfg_err == 1'b0, "R1 error after reset", cfg_err, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1/R4: initial offset is coincident; width 1 keeps it
    run_frame(1, 0, 3, -1, -1, 1, 0);
    // R5: width 5 measured here, syncs after pulse end still coincident
    run_frame(5, -1, -1, 1, 5, 1, 0);
    // R3: offset 4 now in force on every channel
    run_frame(1, 0, 2, 10, 31, 1, 4);
    // R4: back to coincident; program a large width for next frame
    run_frame(201, 0, 7, 14, 30, 1, 0);
    // R3: offset 200; R6: forbidden width measured in this frame
    run_frame(FRAME_CLKS, 0, 4, 9, 31, 1, 200);
    check(cfg_err == 1'b1, "R6 error set", cfg_err, 1);
    // R6: fallback to coincident, error still set until this pulse ends
    run_frame(3, 1, 2, 3, 4, 1, 0);
    check(cfg_err == 1'b0, "R7 error cleared", cfg_err, 0);
    // R8: offset 2, syncs held high three cycles give one strobe each
    run_frame(1, 0, 5, 11, 20, 3, 2);
    // R4: coincident again with held syncs
    run_frame(1, 3, 1, 6, 2, 2, 0);
    check(cfg_err == 1'b0, "R7 error stays clear", cfg_err, 0);
    finish_run();
  end

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end
endmodule